// File: doc/BRIEF.md
# Two-Way Multi-Channel Processor Mailbox

This block passes short messages between two processors, called side A and side B. Each side has its own simple register port. The two ports share one clock and one register file. For each direction there are NCH channels, four by default. Each channel holds a command word, a data word and a pending flag. Each direction also has one enable register and one status register. The status register holds the pending flags.

To post a message, the sending side writes the channel's command word and then its data word. The data write sets that channel's pending flag in the status register of that direction. The receiving side owns the enable and status registers of the direction it receives. Every channel drives its own interrupt line toward the receiver. The line is a registered level: it is high while the channel is both pending and enabled. The receiver reads the words and then clears the flag by writing a one to its bit in the status register.

Both ports can read every register. Read data is registered. It appears one cycle after the read request and holds until the next read.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every command, data, status and enable register reads as zero. Both interrupt vectors are zero and both read-data outputs are zero.
- R2: Only port A writes the A-to-B words: channel x has its command word at byte offset 0x08+8x and its data word at 0x0C+8x. Only port B writes the B-to-A words: command at 0x30+8x, data at 0x34+8x. Every word can be read back from either port, one cycle after the read request.
- R3: A write to a channel's data word sets bit x (x = channel index) of that direction's status register. The A-to-B status register is at 0x04 and the B-to-A status register is at 0x2C. A write to a command word leaves the status register unchanged.
- R4: The receiver clears pending flags by writing the status register. A data bit of 1 clears the flag at that position. A data bit of 0 leaves the flag unchanged.
- R5: The enable registers hold one bit per channel, at bit position x. The A-to-B enable register is at 0x00 and is written by port B. The B-to-A enable register is at 0x28 and is written by port A. Interrupt line x toward the receiver equals pending[x] AND enable[x]. It changes on the same clock edge as the register write that changes either bit, and it stays high until the flag is cleared or the channel is masked.
- R6: In a cycle where a data write sets a flag and a status write clears the same flag, the flag ends up set.
- R7: A write from the wrong port is ignored, and the register keeps its value. This covers port A writing the A-to-B enable or status register, and port B writing an A-to-B command or data word.
- R8: An offset beyond the last B-to-A data word, or an offset whose two low bits are nonzero, is unmapped. A read from an unmapped offset returns zero. A write to an unmapped offset changes nothing.
- R9: The channels are independent. A data write to channel x changes only status bit x and interrupt line x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A request strobe |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A byte offset |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| b_en | input | 1 | Port B request strobe |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B byte offset |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |
| irq_to_b | output | NCH | Per-channel A-to-B interrupt levels |
| irq_to_a | output | NCH | Per-channel B-to-A interrupt levels |

## Verification
Messages are posted on single channels in both directions, and then on every channel in turn. The status word that follows is checked for the one expected bit, which tells apart a correct channel decode from an off-by-stride one. The enable mask is varied on a channel that stays pending. This shows that the interrupt line is a level that follows both the flag and the mask, and not a pulse. Clear writes are made with zero and with one data bits, and a clear is issued in the same cycle as a set, once on the same channel and once on a different channel. These cases separate write-one-to-clear from plain overwrite and confirm that the set wins. Wrong-port writes and unaligned or out-of-range offsets are read back afterwards to show that they left no trace.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [2:0] {
    RK_NONE = 3'd0,
    RK_EN   = 3'd1,
    RK_ST   = 3'd2,
    RK_CMD  = 3'd3,
    RK_DAT  = 3'd4
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] ch;
  } reg_hit_t;

  // Map a byte offset onto one direction's window that starts at base.
  function automatic reg_hit_t decode(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input logic [31:0] nch);
    reg_hit_t    h;
    logic [31:0] off;
    h.kind = RK_NONE;
    h.ch   = 8'd0;
    off    = addr - base;
    if (addr >= base && off < 32'd8 + 32'd8 * nch && addr[1:0] == 2'b00) begin
      if (off == 32'd0)      h.kind = RK_EN;
      else if (off == 32'd4) h.kind = RK_ST;
      else begin
        h.ch   = 8'((off - 32'd8) >> 3);
        h.kind = (off[2] == 1'b0) ? RK_CMD : RK_DAT;
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/mbox_dir.sv
module mbox_dir
  import mbox_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int BASE = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snd_we,
  input  logic [AW-1:0]           snd_addr,
  input  logic [DW-1:0]           snd_wdata,
  input  logic                    rcv_we,
  input  logic [AW-1:0]           rcv_addr,
  input  logic [DW-1:0]           rcv_wdata,
  output logic [NCH-1:0][DW-1:0]  cmd_o,
  output logic [NCH-1:0][DW-1:0]  dat_o,
  output logic [NCH-1:0]          pend_o,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          irq_o
);

  reg_hit_t sh, rh;
  assign sh = decode(32'(snd_addr), 32'(BASE), 32'(NCH));
  assign rh = decode(32'(rcv_addr), 32'(BASE), 32'(NCH));

  logic [NCH-1:0] set_v, clr_v, pend_n, en_n;
  logic [NCH-1:0] pend_q, en_q, irq_q;
  logic [NCH-1:0][DW-1:0] cmd_q, dat_q;

  generate
    if (DW > NCH) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^rcv_wdata[DW-1:NCH];
    end
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit_cmd, hit_dat;
      assign hit_cmd  = snd_we && sh.kind == RK_CMD && sh.ch == 8'(i);
      assign hit_dat  = snd_we && sh.kind == RK_DAT && sh.ch == 8'(i);
      assign set_v[i] = hit_dat;
      always_ff @(posedge clk) begin
        if (rst) begin
          cmd_q[i] <= '0;
          dat_q[i] <= '0;
        end else begin
          if (hit_cmd) cmd_q[i] <= snd_wdata;
          if (hit_dat) dat_q[i] <= snd_wdata;
        end
      end
    end
  endgenerate

  assign clr_v  = (rcv_we && rh.kind == RK_ST) ? rcv_wdata[NCH-1:0] : '0;
  assign en_n   = (rcv_we && rh.kind == RK_EN) ? rcv_wdata[NCH-1:0] : en_q;
  assign pend_n = (pend_q & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_n;
      en_q   <= en_n;
      irq_q  <= pend_n & en_n;
    end
  end

  assign cmd_o  = cmd_q;
  assign dat_o  = dat_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
  import mbox_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic [AW-1:0]          addr,
  input  logic [NCH-1:0][DW-1:0] ab_cmd,
  input  logic [NCH-1:0][DW-1:0] ab_dat,
  input  logic [NCH-1:0]         ab_pend,
  input  logic [NCH-1:0]         ab_en,
  input  logic [NCH-1:0][DW-1:0] ba_cmd,
  input  logic [NCH-1:0][DW-1:0] ba_dat,
  input  logic [NCH-1:0]         ba_pend,
  input  logic [NCH-1:0]         ba_en,
  output logic [DW-1:0]          word
);

  localparam int SPAN = 8 + 8 * NCH;

  reg_hit_t ha, hb;
  assign ha = decode(32'(addr), 32'd0, 32'(NCH));
  assign hb = decode(32'(addr), 32'(SPAN), 32'(NCH));

  always_comb begin
    word = '0;
    case (ha.kind)
      RK_EN:   word[NCH-1:0] = ab_en;
      RK_ST:   word[NCH-1:0] = ab_pend;
      RK_CMD:  for (int i = 0; i < NCH; i++) if (ha.ch == 8'(i)) word = ab_cmd[i];
      RK_DAT:  for (int i = 0; i < NCH; i++) if (ha.ch == 8'(i)) word = ab_dat[i];
      default: ;
    endcase
    case (hb.kind)
      RK_EN:   word[NCH-1:0] = ba_en;
      RK_ST:   word[NCH-1:0] = ba_pend;
      RK_CMD:  for (int i = 0; i < NCH; i++) if (hb.ch == 8'(i)) word = ba_cmd[i];
      RK_DAT:  for (int i = 0; i < NCH; i++) if (hb.ch == 8'(i)) word = ba_dat[i];
      default: ;
    endcase
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           a_en,
  input  logic           a_we,
  input  logic [AW-1:0]  a_addr,
  input  logic [DW-1:0]  a_wdata,
  output logic [DW-1:0]  a_rdata,
  input  logic           b_en,
  input  logic           b_we,
  input  logic [AW-1:0]  b_addr,
  input  logic [DW-1:0]  b_wdata,
  output logic [DW-1:0]  b_rdata,
  output logic [NCH-1:0] irq_to_b,
  output logic [NCH-1:0] irq_to_a
);

  localparam int SPAN = 8 + 8 * NCH;

  logic a_wr, b_wr;
  assign a_wr = a_en && a_we;
  assign b_wr = b_en && b_we;

  logic [NCH-1:0][DW-1:0] a2b_cmd, a2b_dat, b2a_cmd, b2a_dat;
  logic [NCH-1:0]         a2b_pend, a2b_en, b2a_pend, b2a_en;

  mbox_dir #(.NCH(NCH), .DW(DW), .AW(AW), .BASE(0)) u_a2b (
    .clk(clk), .rst(rst),
    .snd_we(a_wr), .snd_addr(a_addr), .snd_wdata(a_wdata),
    .rcv_we(b_wr), .rcv_addr(b_addr), .rcv_wdata(b_wdata),
    .cmd_o(a2b_cmd), .dat_o(a2b_dat), .pend_o(a2b_pend), .en_o(a2b_en),
    .irq_o(irq_to_b)
  );

  mbox_dir #(.NCH(NCH), .DW(DW), .AW(AW), .BASE(SPAN)) u_b2a (
    .clk(clk), .rst(rst),
    .snd_we(b_wr), .snd_addr(b_addr), .snd_wdata(b_wdata),
    .rcv_we(a_wr), .rcv_addr(a_addr), .rcv_wdata(a_wdata),
    .cmd_o(b2a_cmd), .dat_o(b2a_dat), .pend_o(b2a_pend), .en_o(b2a_en),
    .irq_o(irq_to_a)
  );

  logic [DW-1:0] mux_a, mux_b, a_rdata_q, b_rdata_q;

  mbox_rdmux #(.NCH(NCH), .DW(DW), .AW(AW)) u_rd_a (
    .addr(a_addr),
    .ab_cmd(a2b_cmd), .ab_dat(a2b_dat), .ab_pend(a2b_pend), .ab_en(a2b_en),
    .ba_cmd(b2a_cmd), .ba_dat(b2a_dat), .ba_pend(b2a_pend), .ba_en(b2a_en),
    .word(mux_a)
  );

  mbox_rdmux #(.NCH(NCH), .DW(DW), .AW(AW)) u_rd_b (
    .addr(b_addr),
    .ab_cmd(a2b_cmd), .ab_dat(a2b_dat), .ab_pend(a2b_pend), .ab_en(a2b_en),
    .ba_cmd(b2a_cmd), .ba_dat(b2a_dat), .ba_pend(b2a_pend), .ba_en(b2a_en),
    .word(mux_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata_q <= '0;
      b_rdata_q <= '0;
    end else begin
      if (a_en && !a_we) a_rdata_q <= mux_a;
      if (b_en && !b_we) b_rdata_q <= mux_b;
    end
  end

  assign a_rdata = a_rdata_q;
  assign b_rdata = b_rdata_q;

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   a_en,
  input logic                   a_we,
  input logic [AW-1:0]          a_addr,
  input logic                   b_en,
  input logic                   b_we,
  input logic [AW-1:0]          b_addr,
  input logic [NCH-1:0]         b_wdata,
  input logic [NCH-1:0][DW-1:0] a2b_cmd,
  input logic [NCH-1:0]         a2b_pend,
  input logic [NCH-1:0]         a2b_en,
  input logic [NCH-1:0]         b2a_pend,
  input logic [NCH-1:0]         b2a_en,
  input logic [NCH-1:0]         irq_to_b,
  input logic [NCH-1:0]         irq_to_a
);

  localparam int SPAN = 8 + 8 * NCH;

  // R1
  irq_reset_chk: assert property (@(posedge clk) rst |=> (irq_to_b == '0 && irq_to_a == '0));

  // R5
  irq_b_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_to_b == (a2b_pend & a2b_en));

  // R5
  irq_a_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_to_a == (b2a_pend & b2a_en));

  // R7
  cmd_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_en && a_we) |=> $stable(a2b_cmd));

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_k
      localparam logic [AW-1:0] DA = AW'(12 + 8 * k);
      localparam logic [AW-1:0] DB = AW'(SPAN + 12 + 8 * k);
      // R3, R6
      set_a2b_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && a_addr == DA) |=> a2b_pend[k]);
      // R3, R6
      set_b2a_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we && b_addr == DB) |=> b2a_pend[k]);
      // R4
      clr_a2b_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we && b_addr == AW'(4) && b_wdata[k] &&
         !(a_en && a_we && a_addr == DA)) |=> !a2b_pend[k]);
    end
  endgenerate

endmodule

bind ipc_mailbox mbox_chk #(.NCH(NCH), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata[NCH-1:0]),
  .a2b_cmd(a2b_cmd), .a2b_pend(a2b_pend), .a2b_en(a2b_en),
  .b2a_pend(b2a_pend), .b2a_en(b2a_en),
  .irq_to_b(irq_to_b), .irq_to_a(irq_to_a)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;

  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic [NCH-1:0] irq_to_b, irq_to_a;

  int vec = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipc_mailbox #(.NCH(NCH), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_to_b(irq_to_b), .irq_to_a(irq_to_a)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      bad = bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_a(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    @(negedge clk); a_en = 1; a_we = 1; a_addr = ad; a_wdata = d;
    @(negedge clk); a_en = 0; a_we = 0;
  endtask

  task automatic wr_b(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    @(negedge clk); b_en = 1; b_we = 1; b_addr = ad; b_wdata = d;
    @(negedge clk); b_en = 0; b_we = 0;
  endtask

  task automatic wr_ab(input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                       input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    @(negedge clk);
    a_en = 1; a_we = 1; a_addr = aa; a_wdata = ad;
    b_en = 1; b_we = 1; b_addr = ba; b_wdata = bd;
    @(negedge clk); a_en = 0; a_we = 0; b_en = 0; b_we = 0;
  endtask

  task automatic rd_a(input logic [AW-1:0] ad, output logic [DW-1:0] d);
    @(negedge clk); a_en = 1; a_we = 0; a_addr = ad;
    @(negedge clk); a_en = 0; d = a_rdata;
  endtask

  task automatic rd_b(input logic [AW-1:0] ad, output logic [DW-1:0] d);
    @(negedge clk); b_en = 1; b_we = 0; b_addr = ad;
    @(negedge clk); b_en = 0; d = b_rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 a_rdata", a_rdata, 0);
    chk("R1 b_rdata", b_rdata, 0);
    chk("R1 irq_to_b", 32'(irq_to_b), 0);
    chk("R1 irq_to_a", 32'(irq_to_a), 0);
    rd_a(8'h00, d); chk("R1 a2b enable", d, 0);
    rd_b(8'h04, d); chk("R1 a2b status", d, 0);
    rd_a(8'h48, d); chk("R1 b2a cmd3", d, 0);
    rd_b(8'h2C, d); chk("R1 b2a status", d, 0);
  endtask

  task automatic t_post();
    logic [DW-1:0] d;
    wr_a(8'h10, 32'hC0DE0001);
    rd_b(8'h04, d); chk("R3 cmd write leaves status", d, 0);
    wr_a(8'h14, 32'hDA7A0001);
    rd_b(8'h10, d); chk("R2 b reads a2b cmd1", d, 32'hC0DE0001);
    rd_b(8'h14, d); chk("R2 b reads a2b dat1", d, 32'hDA7A0001);
    rd_a(8'h14, d); chk("R2 a reads a2b dat1", d, 32'hDA7A0001);
    rd_b(8'h04, d); chk("R3 status after post ch1", d, 32'h2);
    chk("R5 masked irq stays low", 32'(irq_to_b), 0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] d;
    wr_b(8'h00, 32'hFFFF_FFFF);
    chk("R5 irq after enable", 32'(irq_to_b), 32'h2);
    rd_a(8'h00, d); chk("R5 enable readback low bits", d, 32'hF);
    wr_b(8'h00, 32'hD);
    chk("R5 irq masked ch1", 32'(irq_to_b), 0);
    wr_b(8'h00, 32'hF);
    chk("R5 irq level returns", 32'(irq_to_b), 32'h2);
    repeat (3) @(negedge clk);
    chk("R5 irq held as level", 32'(irq_to_b), 32'h2);
  endtask

  task automatic t_clear();
    logic [DW-1:0] d;
    wr_b(8'h04, 32'h0);
    rd_a(8'h04, d); chk("R4 zero write keeps flag", d, 32'h2);
    wr_b(8'h04, 32'hD);
    rd_a(8'h04, d); chk("R4 other ones keep flag", d, 32'h2);
    wr_b(8'h04, 32'h2);
    rd_a(8'h04, d); chk("R4 one clears flag", d, 0);
    chk("R4 irq drops on clear", 32'(irq_to_b), 0);
  endtask

  task automatic t_own();
    logic [DW-1:0] d;
    wr_a(8'h1C, 32'h0000_0002);
    wr_a(8'h04, 32'hF);
    rd_b(8'h04, d); chk("R7 a cannot clear a2b status", d, 32'h4);
    wr_a(8'h00, 32'h0);
    rd_b(8'h00, d); chk("R7 a cannot write a2b enable", d, 32'hF);
    wr_b(8'h08, 32'h1234_5678);
    rd_a(8'h08, d); chk("R7 b cannot write a2b cmd", d, 0);
    wr_b(8'h0C, 32'h5555_0000);
    rd_a(8'h04, d); chk("R7 b data write no a2b flag", d, 32'h4);
    wr_b(8'h04, 32'h4);
  endtask

  task automatic t_b2a();
    logic [DW-1:0] d;
    wr_b(8'h48, 32'hB0B0_0003);
    wr_b(8'h4C, 32'hB0B0_1003);
    rd_a(8'h2C, d); chk("R3 b2a status ch3", d, 32'h8);
    rd_a(8'h4C, d); chk("R2 a reads b2a dat3", d, 32'hB0B0_1003);
    wr_a(8'h28, 32'hF);
    chk("R5 irq_to_a ch3", 32'(irq_to_a), 32'h8);
    wr_a(8'h2C, 32'h8);
    chk("R4 irq_to_a cleared", 32'(irq_to_a), 0);
    for (int k = 0; k < NCH; k++) begin
      wr_b(8'(52 + 8 * k), 32'(k));
      rd_a(8'h2C, d); chk("R9 b2a single bit", d, 32'(1 << k));
      chk("R9 irq_to_a single line", 32'(irq_to_a), 32'(1 << k));
      wr_a(8'h2C, 32'(1 << k));
    end
    for (int k = 0; k < NCH; k++) begin
      wr_a(8'(12 + 8 * k), 32'(k));
      chk("R9 irq_to_b single line", 32'(irq_to_b), 32'(1 << k));
      wr_b(8'h04, 32'hF);
    end
  endtask

  task automatic t_race();
    logic [DW-1:0] d;
    wr_a(8'h0C, 32'hAAAA_0000);
    wr_ab(8'h0C, 32'hAAAA_0001, 8'h04, 32'h1);
    rd_b(8'h04, d); chk("R6 set wins same channel", d, 32'h1);
    wr_ab(8'h14, 32'hAAAA_0002, 8'h04, 32'h1);
    rd_b(8'h04, d); chk("R6 clear other channel", d, 32'h2);
    chk("R6 irq follows", 32'(irq_to_b), 32'h2);
    wr_b(8'h04, 32'hF);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d;
    rd_a(8'h50, d); chk("R8 read past end", d, 0);
    rd_b(8'hFC, d); chk("R8 read top offset", d, 0);
    rd_a(8'h0D, d); chk("R8 read unaligned", d, 0);
    wr_a(8'h0D, 32'h7777_7777);
    rd_b(8'h0C, d); chk("R8 unaligned write ignored", d, 32'hAAAA_0001);
    rd_b(8'h04, d); chk("R8 unaligned write no flag", d, 0);
    wr_b(8'h50, 32'hFFFF_FFFF);
    wr_a(8'h52, 32'hFFFF_FFFF);
    rd_a(8'h2C, d); chk("R8 out of range no b2a flag", d, 0);
    rd_a(8'h28, d); chk("R8 b2a enable unchanged", d, 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_post();
    t_enable();
    t_clear();
    t_own();
    t_b2a();
    t_race();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule